// File: doc/BRIEF.md
# Multi-Standard Byte-Wise CRC Engine

This block computes a cyclic redundancy check over a byte stream, taking one 8-bit byte per clock into a running checksum register. A small mode input picks one of five common CRC variants at 8, 16 or 32 bits. The variants cover both the reflected form, where the register shifts toward bit 0, and the normal form, where it shifts toward the top bit. Two flags choose whether the register starts from all ones instead of zero, and whether the result is complemented before it is handed out.

A message begins with a start strobe, which loads the initial value and latches the mode and both flags for the rest of the message. Each byte arrives with a valid qualifier. A finish strobe closes the message: one cycle later the final checksum appears on the result port with a one-cycle done pulse, and the result stays there until the next start. The byte update is a single combinational network that unrolls the eight bit steps, so the stream can run back to back at one byte per cycle.

Top module: `crc_mb_engine`

## Requirements
- R1: Bits of `crc_o` above the selected width always read zero. An 8-bit result occupies bits 7:0 and a 16-bit result occupies bits 15:0.
- R2: The mode code selects the variant. Code 0 is 32-bit reflected with polynomial 0xEDB88320. Code 1 is 16-bit reflected with 0xA001. Code 2 is 16-bit normal with 0x1021. Code 3 is 8-bit normal with 0x07. Code 4 is 8-bit reflected with 0x8C.
- R3: On start, the register loads all ones of the selected width when `pre_inv_i` is 1, and zero otherwise. Mode and both flags are captured at start, so changing them during a message has no effect on its result.
- R4: In reflected modes, each byte is XORed into the low 8 bits of the register and then goes through eight right-shift steps with conditional polynomial XOR. The register shifted right by 8 is XORed back in afterwards. For example, code 0 with both inversions gives 0xCBF43926 for the ASCII string "123456789".
- R5: In normal modes, each byte is XORed into the top 8 bits of the register and then goes through eight left-shift steps with conditional polynomial XOR. For example, code 2 without inversion gives 0x31C3 for "123456789", and with pre-inversion only it gives 0x29B1.
- R6: A cycle with `valid_i` low leaves the checksum register unchanged.
- R7: A finish strobe raises `done_o` for exactly one cycle, one clock edge later. In that same cycle `crc_o` shows the final register value, XORed with all ones of the width when the post-inversion flag was set at start.
- R8: `crc_o` holds its value until the next start, and a start clears it to zero.
- R9: Start has priority. A byte or a finish strobe in the start cycle is ignored.
- R10: Mode codes 5 to 7 behave as code 0.
- R11: One byte is absorbed on every valid cycle with no gaps needed. A byte given in the same cycle as finish is part of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new message |
| mode_i | input | 3 | Variant select, sampled at start |
| pre_inv_i | input | 1 | Start from all ones, sampled at start |
| post_inv_i | input | 1 | Complement the result, sampled at start |
| valid_i | input | 1 | Byte on data_i is to be absorbed |
| data_i | input | 8 | Message byte |
| finish_i | input | 1 | Close the message |
| crc_o | output | 32 | Final checksum, zero-extended |
| done_o | output | 1 | One-cycle result pulse |

## Verification
A start or a byte changes the register at the clock edge where it is sampled. A finish puts the result on `crc_o` and `done_o` at the clock edge where finish is sampled, and `done_o` falls at the next edge. The bench drives inputs on falling edges. It checks result and pulse at the falling edge right after the finish edge, and again one edge later to confirm that the pulse has ended and the value is held. Every expected value comes from a bit-serial model in the bench that walks each byte one bit at a time. The bench also checks the published check values for the string "123456789".

// File: rtl/crc_mb_pkg.sv
package crc_mb_pkg;
  localparam int unsigned CRC_MAXW = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned MODE_W   = 3;
  localparam int unsigned IDX_W    = $clog2(CRC_MAXW);

  typedef enum logic [MODE_W-1:0] {
    MODE_R32 = 3'd0,
    MODE_R16 = 3'd1,
    MODE_L16 = 3'd2,
    MODE_L8  = 3'd3,
    MODE_R8  = 3'd4
  } crc_mode_e;

  typedef struct packed {
    logic [CRC_MAXW-1:0] poly;
    logic [CRC_MAXW-1:0] mask;
    logic [IDX_W-1:0]    top_idx;
    logic                refl;
  } crc_cfg_t;
endpackage

// File: rtl/crc_mb_cfg.sv
module crc_mb_cfg
  import crc_mb_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output crc_cfg_t          cfg_o
);
  localparam logic [CRC_MAXW-1:0] ALL_ONES = '1;
  localparam logic [IDX_W-1:0]    TOP_MAX  = IDX_W'(CRC_MAXW - 1);

  logic [IDX_W-1:0] top_idx;

  always_comb begin
    cfg_o = '0;
    case (crc_mode_e'(mode_i))
      MODE_R16: begin cfg_o.poly = CRC_MAXW'(32'h0000_A001); top_idx = IDX_W'(15); cfg_o.refl = 1'b1; end
      MODE_L16: begin cfg_o.poly = CRC_MAXW'(32'h0000_1021); top_idx = IDX_W'(15); cfg_o.refl = 1'b0; end
      MODE_L8:  begin cfg_o.poly = CRC_MAXW'(32'h0000_0007); top_idx = IDX_W'(7);  cfg_o.refl = 1'b0; end
      MODE_R8:  begin cfg_o.poly = CRC_MAXW'(32'h0000_008C); top_idx = IDX_W'(7);  cfg_o.refl = 1'b1; end
      default:  begin cfg_o.poly = CRC_MAXW'(32'hEDB8_8320); top_idx = TOP_MAX;    cfg_o.refl = 1'b1; end
    endcase
    cfg_o.top_idx = top_idx;
    cfg_o.mask    = ALL_ONES >> (TOP_MAX - top_idx);
  end

  // R1: every preset covers at least one full byte
  always_comb begin
    p_mask_byte_r1: assert (cfg_o.mask[BYTE_W-1:0] == {BYTE_W{1'b1}});
  end
endmodule

// File: rtl/crc_mb_step.sv
module crc_mb_step
  import crc_mb_pkg::*;
#(
  parameter int unsigned STEPS = BYTE_W
)(
  input  crc_cfg_t            cfg_i,
  input  logic [CRC_MAXW-1:0] crc_i,
  input  logic [BYTE_W-1:0]   data_i,
  output logic [CRC_MAXW-1:0] crc_o
);
  localparam logic [CRC_MAXW-1:0] BYTE_MASK = {{(CRC_MAXW-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [CRC_MAXW-1:0] data_ext;
  logic [IDX_W-1:0]    lift;
  logic [CRC_MAXW-1:0] chain [0:STEPS];

  assign data_ext = {{(CRC_MAXW-BYTE_W){1'b0}}, data_i};
  assign lift     = cfg_i.top_idx - IDX_W'(BYTE_W - 1);

  // Seed of the unrolled chain: byte folded into the low or the high end
  always_comb begin
    if (cfg_i.refl) chain[0] = (crc_i ^ data_ext) & BYTE_MASK;
    else            chain[0] = (crc_i ^ (data_ext << lift)) & cfg_i.mask;
  end

  for (genvar k = 0; k < STEPS; k++) begin : g_bit
    logic                fb;
    logic [CRC_MAXW-1:0] moved;
    always_comb begin
      fb    = cfg_i.refl ? chain[k][0] : chain[k][cfg_i.top_idx];
      moved = cfg_i.refl ? (chain[k] >> 1) : (chain[k] << 1);
      chain[k+1] = (moved ^ (fb ? cfg_i.poly : '0)) & cfg_i.mask;
    end
  end

  always_comb begin
    if (cfg_i.refl) crc_o = ((crc_i >> BYTE_W) ^ chain[STEPS]) & cfg_i.mask;
    else            crc_o = chain[STEPS];
  end
endmodule

// File: rtl/crc_mb_engine.sv
module crc_mb_engine
  import crc_mb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic                pre_inv_i,
  input  logic                post_inv_i,
  input  logic                valid_i,
  input  logic [BYTE_W-1:0]   data_i,
  input  logic                finish_i,
  output logic [CRC_MAXW-1:0] crc_o,
  output logic                done_o
);
  crc_cfg_t            cfg_d, cfg_q;
  logic                post_q;
  logic                pre_q;
  logic [CRC_MAXW-1:0] crc_q;
  logic [CRC_MAXW-1:0] crc_next;
  logic [CRC_MAXW-1:0] crc_last;

  crc_mb_cfg u_cfg (
    .mode_i (mode_i),
    .cfg_o  (cfg_d)
  );

  crc_mb_step #(.STEPS(BYTE_W)) u_step (
    .cfg_i  (cfg_q),
    .crc_i  (crc_q),
    .data_i (data_i),
    .crc_o  (crc_next)
  );

  assign crc_last = valid_i ? crc_next : crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      post_q <= 1'b0;
      pre_q  <= 1'b0;
      crc_q  <= '0;
      crc_o  <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      cfg_q  <= cfg_d;
      post_q <= post_inv_i;
      pre_q  <= pre_inv_i;
      crc_q  <= pre_inv_i ? cfg_d.mask : '0;
      crc_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (valid_i)  crc_q <= crc_next;
      if (finish_i) crc_o <= crc_last ^ (post_q ? cfg_q.mask : '0);
    end
  end

  p_start_load_r3: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (crc_q == (pre_q ? cfg_q.mask : '0)));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !valid_i) |=> $stable(crc_q));
  p_width_r1: assert property (@(posedge clk) disable iff (rst)
    (crc_o & ~cfg_q.mask) == '0);
  p_done_rise_r7: assert property (@(posedge clk) disable iff (rst)
    (finish_i && !start_i) |=> done_o);
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !(finish_i && !start_i) |=> !done_o);
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !finish_i) |=> $stable(crc_o));
  p_start_wins_r9: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (crc_o == '0 && !done_o));
endmodule

// File: tb/crc_mb_engine_tb_top.sv
`timescale 1ns/1ps
module crc_mb_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i, pre_inv_i, post_inv_i, valid_i, finish_i;
  logic [2:0]  mode_i;
  logic [7:0]  data_i;
  logic [31:0] crc_o;
  logic        done_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] msg [0:299];

  always #2 clk = ~clk;

  crc_mb_engine dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .pre_inv_i(pre_inv_i), .post_inv_i(post_inv_i), .valid_i(valid_i),
    .data_i(data_i), .finish_i(finish_i), .crc_o(crc_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void preset(input logic [2:0] m, output int w,
                                 output logic [31:0] poly, output bit refl);
    case (m)
      3'd1: begin w = 16; poly = 32'hA001; refl = 1; end
      3'd2: begin w = 16; poly = 32'h1021; refl = 0; end
      3'd3: begin w = 8;  poly = 32'h07;   refl = 0; end
      3'd4: begin w = 8;  poly = 32'h8C;   refl = 1; end
      default: begin w = 32; poly = 32'hEDB88320; refl = 1; end
    endcase
  endfunction

  // Bit-serial model: one message bit per step
  function automatic logic [31:0] model(input logic [2:0] m, input bit pre,
                                        input bit post, input int n);
    int w; logic [31:0] poly; bit refl; logic [31:0] mask, c; bit fb;
    preset(m, w, poly, refl);
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    c = pre ? mask : 0;
    for (int i = 0; i < n; i++) begin
      if (refl) begin
        for (int b = 0; b < 8; b++) begin
          fb = c[0] ^ msg[i][b];
          c = c >> 1;
          if (fb) c = c ^ poly;
        end
      end else begin
        for (int b = 7; b >= 0; b--) begin
          fb = c[w-1] ^ msg[i][b];
          c = (c << 1) & mask;
          if (fb) c = c ^ poly;
        end
      end
    end
    return post ? (c ^ mask) : c;
  endfunction

  // Runs one message; inputs scrambled after start to show they were latched
  task automatic run_msg(input string req, input logic [2:0] m, input bit pre,
                         input bit post, input int n, input bit gaps, input bit fin_last);
    logic [31:0] exp, held;
    exp = model(m, pre, post, n);
    @(negedge clk);
    start_i = 1; mode_i = m; pre_inv_i = pre; post_inv_i = post;
    @(negedge clk);
    start_i = 0; mode_i = 3'($urandom); pre_inv_i = ~pre; post_inv_i = ~post;
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        valid_i = 0; data_i = 8'($urandom); @(negedge clk);
      end
      valid_i = 1; data_i = msg[i];
      finish_i = fin_last && (i == n - 1);
      @(negedge clk);
      valid_i = 0; finish_i = 0;
    end
    if (!fin_last || n == 0) begin
      finish_i = 1; @(negedge clk); finish_i = 0;
    end
    check({req, " R7 done"}, {31'd0, done_o}, 32'd1);
    check({req, " R7 value"}, crc_o, exp);
    held = crc_o;
    @(negedge clk);
    check({req, " R7 pulse ends"}, {31'd0, done_o}, 32'd0);
    check({req, " R8 held"}, crc_o, held);
  endtask

  task automatic load_str();
    string s = "123456789";
    for (int i = 0; i < 9; i++) msg[i] = s[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4242));
    rst = 1; start_i = 0; mode_i = 0; pre_inv_i = 0; post_inv_i = 0;
    valid_i = 0; data_i = 0; finish_i = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("reset R8 crc", crc_o, 32'd0);
    check("reset R7 done", {31'd0, done_o}, 32'd0);

    // Published check values
    load_str();
    run_msg("R4 R2 ref32", 3'd0, 1, 1, 9, 0, 0); check("R4 known", crc_o, 32'hCBF43926);
    run_msg("R4 R2 ref16", 3'd1, 0, 0, 9, 0, 0); check("R4 known16", crc_o, 32'h0000BB3D);
    run_msg("R5 R2 nrm16", 3'd2, 0, 0, 9, 0, 0); check("R5 known", crc_o, 32'h000031C3);
    run_msg("R5 R3 nrm16pre", 3'd2, 1, 0, 9, 0, 0); check("R5 R3 known", crc_o, 32'h000029B1);
    run_msg("R5 R2 nrm8", 3'd3, 0, 0, 9, 0, 0); check("R5 known8", crc_o, 32'h000000F4);
    run_msg("R4 R2 ref8", 3'd4, 0, 0, 9, 0, 0); check("R4 known8", crc_o, 32'h000000A1);
    check("R1 upper bits 8-bit", {8'd0, crc_o[31:8]}, 32'd0);

    // Every byte value, every preset, every flag pair
    for (int i = 0; i < 256; i++) msg[i] = 8'(i);
    for (int m = 0; m < 5; m++)
      for (int f = 0; f < 4; f++)
        run_msg("R2 R11 sweep", 3'(m), f[0], f[1], 256, 0, 1);

    // Random messages, random gaps, codes 5 to 7 included
    for (int t = 0; t < 60; t++) begin
      int n = 1 + ($urandom % 64);
      for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
      run_msg("R6 R10 R3 random", 3'($urandom), 1'($urandom), 1'($urandom), n, 1, 1'($urandom));
    end
    msg[0] = 8'h5A; msg[1] = 8'hC3;
    run_msg("R10 code5", 3'd5, 1, 0, 2, 0, 0);
    check("R10 code5 vs code0", crc_o, model(3'd0, 1, 0, 2));
    run_msg("R10 code7", 3'd7, 0, 1, 2, 1, 1);

    // Start priority over byte and finish
    @(negedge clk);
    start_i = 1; mode_i = 3'd1; pre_inv_i = 1; post_inv_i = 1;
    valid_i = 1; data_i = 8'h55; finish_i = 1;
    @(negedge clk);
    start_i = 0; valid_i = 0; finish_i = 0;
    check("R9 no done", {31'd0, done_o}, 32'd0);
    check("R9 R8 cleared", crc_o, 32'd0);
    finish_i = 1; @(negedge clk); finish_i = 0;
    check("R9 R3 byte ignored", crc_o, 32'h0000_0000);

    // Idle cycles leave register alone; result holds; start clears
    msg[0] = 8'h31;
    run_msg("R6 R8 base", 3'd3, 0, 0, 1, 0, 0);
    held = crc_o;
    repeat (5) @(negedge clk);
    check("R8 long hold", crc_o, held);
    finish_i = 1; @(negedge clk); finish_i = 0;
    check("R6 idle keeps register", crc_o, held);
    start_i = 1; mode_i = 3'd0; @(negedge clk); start_i = 0;
    check("R8 start clears", crc_o, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule